// File: doc/BRIEF.md
# Counter Capture/Compare Channel

This block is a single capture/compare slot that sits beside a free-running real-time counter; a counter subsystem instantiates three of them, each with a distinct index. In compare mode the slot holds a value and watches either the main counter or a combined word built from the low 17 counter bits above the 15-bit pre-counter. Any number of the most significant bits, up to 31, can be left out of the comparison. When the comparison first becomes true the slot raises a one-cycle event and drives its output pin with one of four actions.

In capture mode the slot watches an external trigger line for a selectable edge. It copies the main counter into its value register and raises the event together. A write port loads the value register directly in any mode, so software can set the compare value or clear a stale capture. The channel index is a parameter, and an index outside the three-slot range stops elaboration.

Top module: `cc_channel`

## Requirements
- R1: After reset `out_o`, `evt_o` and `val_o` are all zero.
- R2: `mode_i` encodes 0 = off, 1 = capture, 2 = compare, 3 = off. In either off encoding no event is raised, and `val_o` changes only through the write port.
- R3: `base_i` = 0 compares against `cnt_i`. `base_i` = 1 compares against {`cnt_i`[16:0], `pre_i`[14:0]}, so higher counter bits have no effect.
- R4: `mask_i` = n leaves the top n bits of the value out of the compare. Only bits [31-n:0] must agree.
- R5: In compare mode an event is raised only on the clock edge where the masked comparison turns from unequal to equal. `evt_o` is high in the following cycle, for one cycle per match.
- R6: With action 0 (pulse), `out_o` is high for exactly the one cycle in which a compare event is shown, and low otherwise.
- R7: On a compare event, action 1 inverts `out_o`, action 2 drives it low and action 3 drives it high. Without an event these actions hold `out_o`.
- R8: `edge_i` encodes 0 = rising, 1 = falling, 2 = either edge, judged against the trigger level at the previous clock edge. Encoding 3 passes the level through, so every clock edge with the trigger high counts as a hit.
- R9: In capture mode a trigger hit loads `cnt_i` into `val_o` and raises `evt_o` in the same cycle.
- R10: `wr_en_i` loads `wr_val_i` into `val_o` on the next cycle. When a capture hits on the same edge, the write takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | 32 | Main counter value |
| pre_i | input | 15 | Pre-counter value |
| trig_i | input | 1 | External capture trigger |
| mode_i | input | 2 | Channel mode |
| action_i | input | 2 | Output action on a compare match |
| edge_i | input | 2 | Trigger edge selection |
| base_i | input | 1 | Compare base: counter or combined word |
| mask_i | input | 5 | Number of excluded top bits |
| wr_en_i | input | 1 | Value register write strobe |
| wr_val_i | input | 32 | Value to write |
| out_o | output | 1 | Channel output pin |
| evt_o | output | 1 | One-cycle event flag |
| val_o | output | 32 | Value register |

## Verification
The bench builds the slot with its default widths: a 32-bit value, a 15-bit pre-counter and a 5-bit mask, as channel index 2, the highest legal index. At these widths the bench can drive combined-word values whose upper counter bits differ from the stored value. It can also apply masks of 28 and 31 bits, which make the channel match periodically every 16 and every 2 counts. Writes, captures and wraparound all happen within a few hundred cycles.

// File: rtl/cc_pkg.sv
package cc_pkg;

    typedef enum logic [1:0] {
        CC_OFF     = 2'd0,
        CC_CAPTURE = 2'd1,
        CC_COMPARE = 2'd2,
        CC_OFF_ALT = 2'd3
    } cc_mode_e;

    typedef enum logic [1:0] {
        ACT_PULSE  = 2'd0,
        ACT_TOGGLE = 2'd1,
        ACT_CLEAR  = 2'd2,
        ACT_SET    = 2'd3
    } cc_act_e;

    typedef enum logic [1:0] {
        EDG_RISE  = 2'd0,
        EDG_FALL  = 2'd1,
        EDG_BOTH  = 2'd2,
        EDG_LEVEL = 2'd3
    } cc_edge_e;

endpackage

// File: rtl/cc_trig_edge.sv
module cc_trig_edge
    import cc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig_i,
    input  logic [1:0] sel_i,
    output logic       hit_o
);

    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_i;
        unique case (cc_edge_e'(sel_i))
            EDG_RISE:  hit_o = trig_i & ~trig_q;
            EDG_FALL:  hit_o = ~trig_i & trig_q;
            EDG_BOTH:  hit_o = trig_i ^ trig_q;
            default:   hit_o = trig_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

endmodule

// File: rtl/cc_match.sv
module cc_match #(
    parameter int VAL_W  = 32,
    parameter int PRE_W  = 15,
    parameter int MASK_W = 5
) (
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic              base_i,
    input  logic [VAL_W-1:0]  ref_i,
    input  logic [MASK_W-1:0] mask_i,
    output logic              eq_o
);

    localparam int HI_W = VAL_W - PRE_W;

    logic [VAL_W-1:0] base_word;
    logic [VAL_W-1:0] keep;
    logic [VAL_W-1:0] diff;

    always_comb begin
        base_word = base_i ? {cnt_i[HI_W-1:0], pre_i} : cnt_i;
        for (int i = 0; i < VAL_W; i++) begin
            keep[i] = (i < (VAL_W - int'(mask_i)));
        end
        diff = (base_word ^ ref_i) & keep;
        eq_o = (diff == '0);
    end

endmodule

// File: rtl/cc_channel.sv
module cc_channel
    import cc_pkg::*;
#(
    parameter int VAL_W  = 32,
    parameter int PRE_W  = 15,
    parameter int MASK_W = 5,
    parameter int NUM_CH = 3,
    parameter int CH_ID  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VAL_W-1:0]  cnt_i,
    input  logic [PRE_W-1:0]  pre_i,
    input  logic              trig_i,
    input  logic [1:0]        mode_i,
    input  logic [1:0]        action_i,
    input  logic [1:0]        edge_i,
    input  logic              base_i,
    input  logic [MASK_W-1:0] mask_i,
    input  logic              wr_en_i,
    input  logic [VAL_W-1:0]  wr_val_i,
    output logic              out_o,
    output logic              evt_o,
    output logic [VAL_W-1:0]  val_o
);

    generate
        if (CH_ID < 0 || CH_ID >= NUM_CH) begin : g_bad_index
            $error("cc_channel: channel index out of range");
        end
    endgenerate

    typedef struct packed {
        logic             out;
        logic             evt;
        logic             seen;
        logic [VAL_W-1:0] val;
    } ch_state_t;

    ch_state_t st_d, st_q;

    logic trig_hit;
    logic eq_now;

    cc_trig_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .sel_i  (edge_i),
        .hit_o  (trig_hit)
    );

    cc_match #(
        .VAL_W  (VAL_W),
        .PRE_W  (PRE_W),
        .MASK_W (MASK_W)
    ) u_match (
        .cnt_i  (cnt_i),
        .pre_i  (pre_i),
        .base_i (base_i),
        .ref_i  (st_q.val),
        .mask_i (mask_i),
        .eq_o   (eq_now)
    );

    logic cap_hit;
    logic cmp_hit;

    always_comb begin
        st_d    = st_q;
        cap_hit = (cc_mode_e'(mode_i) == CC_CAPTURE) && trig_hit;
        cmp_hit = (cc_mode_e'(mode_i) == CC_COMPARE) && eq_now && !st_q.seen;

        st_d.seen = eq_now;
        st_d.evt  = cap_hit | cmp_hit;

        if (wr_en_i)      st_d.val = wr_val_i;
        else if (cap_hit) st_d.val = cnt_i;

        unique case (cc_act_e'(action_i))
            ACT_PULSE:  st_d.out = cmp_hit;
            ACT_TOGGLE: if (cmp_hit) st_d.out = ~st_q.out;
            ACT_CLEAR:  if (cmp_hit) st_d.out = 1'b0;
            default:    if (cmp_hit) st_d.out = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o = st_q.out;
    assign evt_o = st_q.evt;
    assign val_o = st_q.val;

endmodule

// File: rtl/cc_channel_chk.sv
module cc_channel_chk #(
    parameter int VAL_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_i,
    input logic [1:0]       action_i,
    input logic [VAL_W-1:0] cnt_i,
    input logic             wr_en_i,
    input logic [VAL_W-1:0] wr_val_i,
    input logic             out_o,
    input logic             evt_o,
    input logic [VAL_W-1:0] val_o
);

    AST_OFF_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_i) == 2'd0 || $past(mode_i) == 2'd3) |-> !evt_o); // R2

    AST_MATCH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && $past(mode_i) == 2'd2) |=> !(evt_o && $past(mode_i) == 2'd2)); // R5

    AST_PULSE_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_o && $past(action_i) == 2'd0) |-> !out_o); // R6

    AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && $past(mode_i) == 2'd2 && $past(action_i) == 2'd3) |-> out_o); // R7

    AST_CLEAR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && $past(mode_i) == 2'd2 && $past(action_i) == 2'd2) |-> !out_o); // R7

    AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && $past(mode_i) == 2'd1 && !$past(wr_en_i)) |-> val_o == $past(cnt_i)); // R9

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en_i) |-> val_o == $past(wr_val_i)); // R10

endmodule

bind cc_channel cc_channel_chk #(.VAL_W(VAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .action_i (action_i),
    .cnt_i    (cnt_i),
    .wr_en_i  (wr_en_i),
    .wr_val_i (wr_val_i),
    .out_o    (out_o),
    .evt_o    (evt_o),
    .val_o    (val_o)
);

// File: tb/cc_channel_tb.sv
`timescale 1ns/1ps
module cc_channel_tb;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cnt;
    logic [14:0] pre;
    logic        trig;
    logic [1:0]  mode, action, edg;
    logic        base;
    logic [4:0]  mask;
    logic        wr_en;
    logic [31:0] wr_val;
    logic        out_o, evt_o;
    logic [31:0] val_o;

    int    n_vec  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    always #(PERIOD/2) clk = ~clk;

    cc_channel #(.CH_ID(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .pre_i(pre), .trig_i(trig),
        .mode_i(mode), .action_i(action), .edge_i(edg), .base_i(base),
        .mask_i(mask), .wr_en_i(wr_en), .wr_val_i(wr_val),
        .out_o(out_o), .evt_o(evt_o), .val_o(val_o)
    );

    // behavioural reference model
    bit          m_out, m_evt, m_seen, m_trig;
    logic [31:0] m_val;

    function automatic bit ref_equal(logic [31:0] c, logic [14:0] p, bit b,
                                     logic [31:0] v, int n);
        logic [31:0] w;
        if (b) begin
            for (int i = 0; i < 15; i++) w[i] = p[i];
            for (int i = 15; i < 32; i++) w[i] = c[i-15];
        end else begin
            w = c;
        end
        for (int i = 0; i < 32 - n; i++) if (w[i] !== v[i]) return 0;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_out = 0; m_evt = 0; m_seen = 0; m_trig = 0; m_val = 0;
        end else begin
            bit eq, hit, cap, cmp;
            eq = ref_equal(cnt, pre, base, m_val, int'(mask));
            case (edg)
                2'd0: hit = trig && !m_trig;
                2'd1: hit = !trig && m_trig;
                2'd2: hit = trig != m_trig;
                default: hit = trig;
            endcase
            cap = (mode == 2'd1) && hit;
            cmp = (mode == 2'd2) && eq && !m_seen;
            m_seen = eq;
            m_trig = trig;
            m_evt  = cap || cmp;
            if (wr_en) m_val = wr_val;
            else if (cap) m_val = cnt;
            case (action)
                2'd0: m_out = cmp;
                2'd1: if (cmp) m_out = !m_out;
                2'd2: if (cmp) m_out = 0;
                default: if (cmp) m_out = 1;
            endcase
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "out_o", {31'd0, out_o}, {31'd0, m_out});
            check(cur_req, "evt_o", {31'd0, evt_o}, {31'd0, m_evt});
            check(cur_req, "val_o", val_o, m_val);
        end
    end

    task automatic tick(int n, bit count);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            wr_en = 0;
            if (count) cnt = cnt + 1;
        end
    endtask

    task automatic write_val(logic [31:0] v);
        wr_en = 1; wr_val = v;
        tick(1, 0);
    endtask

    int evt_count;
    always @(negedge clk) if (rst_n && evt_o) evt_count++;

    initial begin
        rst_n = 0; cnt = 0; pre = 0; trig = 0; mode = 0; action = 0;
        edg = 0; base = 0; mask = 0; wr_en = 0; wr_val = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("R1", "reset out", {31'd0, out_o}, 32'd0);
        check("R1", "reset evt", {31'd0, evt_o}, 32'd0);
        check("R1", "reset val", val_o, 32'd0);
        @(posedge clk); #1;

        // R5: single event per match, directed count
        cur_req = "R5";
        write_val(32'd20);
        mode = 2; action = 0; cnt = 0; evt_count = 0;
        tick(40, 1);
        tick(1, 0);
        check("R5", "match event count", evt_count, 32'd1);

        // R6: pulse action with held counter
        cur_req = "R6";
        cnt = 7; write_val(32'd7);
        tick(6, 0);
        cnt = 0; tick(12, 1);

        // R7: toggle across wrap, then clear and set
        cur_req = "R7";
        action = 1; write_val(32'd10); cnt = 0;
        for (int r = 0; r < 3; r++) begin cnt = 0; tick(15, 1); end
        action = 2; cnt = 0; tick(15, 1);
        action = 3; cnt = 0; tick(15, 1);
        action = 2; cnt = 0; tick(15, 1);

        // R3: combined base, high counter bits ignored
        cur_req = "R3";
        action = 0; base = 1;
        write_val({17'd3, 15'd5});
        cnt = 32'h0010_0003; pre = 0;
        for (int k = 0; k < 12; k++) begin pre = pre + 1; tick(1, 0); end
        cnt = 32'h0000_0004; pre = 5; tick(3, 0);
        base = 0; pre = 0;

        // R4: masked compare
        cur_req = "R4";
        mask = 28; write_val(32'hFFFF_FFF5); cnt = 0; evt_count = 0;
        tick(50, 1);
        tick(1, 0);
        check("R4", "mask 28 event count", evt_count, 32'd3);
        mask = 31; cnt = 0; tick(10, 1);
        mask = 0;

        // R2: off encodings
        cur_req = "R2";
        write_val(32'd5);
        mode = 0; cnt = 0; action = 3;
        for (int k = 0; k < 12; k++) begin trig = k[0]; tick(1, 1); end
        mode = 3; cnt = 0;
        for (int k = 0; k < 12; k++) begin trig = k[1]; tick(1, 1); end
        trig = 0; action = 0;

        // R8/R9: capture edges
        mode = 1; cnt = 100;
        for (int e = 0; e < 4; e++) begin
            cur_req = (e == 3) ? "R8" : "R9";
            edg = e[1:0];
            for (int k = 0; k < 16; k++) begin
                trig = (k % 5 == 1) || (k % 5 == 2) || (k == 9);
                tick(1, 1);
            end
            trig = 0; tick(2, 1);
        end

        // R10: write beats capture
        cur_req = "R10";
        edg = 3; trig = 1; wr_en = 1; wr_val = 32'hDEAD_BEEF;
        @(posedge clk); #1; wr_en = 0;
        @(negedge clk);
        check("R10", "write priority", val_o, 32'hDEAD_BEEF);
        trig = 0; mode = 0;
        write_val(32'h1234_5678);
        tick(3, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule